// File: doc/BRIEF.md
# Dual-task register programming sequencer

This block is a small command processor that runs two identical, independent tasks side by side. Each task walks a list of 32-bit commands held in system memory and uses them to program a register bus. A command can write a register, copy a register's contents out to memory, raise or drop shared flags, pause until a hardware condition is true, branch on a condition, or end the task.

Each task has its own context: a start program counter, a page that supplies the upper memory address bits, and a pause timeout. A host starts a task with a one-cycle start pulse. The task then runs until it executes a stop command or a pause times out, and the host watches its busy, done and timeout outputs.

The two tasks coordinate with each other and with the host through five shared flags. When both tasks want the outside ports in the same cycle, a round-robin arbiter gives the memory port and the register port to one of them. The memory port uses a request/acknowledge handshake, and read data comes back in the acknowledge cycle. Register reads on the register port complete in the same cycle.

Top module: `dual_cmd_seq`

## Requirements
- R1: After reset both tasks are idle (busy low), all five flags are 0, and no memory request, done pulse or timeout status is present.
- R2: A start pulse for an idle task raises its busy output and starts fetching at address {page, start PC} in the next cycle. A start pulse for a task that is already busy is ignored, and that task's program counter is left unchanged.
- R3: Opcode 0 (load, in bits [31:28]) fetches the next word and writes it to the register whose index is in bits [3:0].
- R4: Opcode 1 (upload) fetches the next word as a memory address (its low 10 bits). It reads the register indexed by bits [3:0] and writes that value to that memory address.
- R5: Opcode 2 sets, and opcode 3 clears, the flags selected by mask bits [4:0]. The host can also set and clear flags. In any cycle, a set request for a flag wins over a clear request for the same flag.
- R6: Opcode 4 (pause) stalls its task until a bit selected by the mask in bits [12:0] is true. The condition vector carries the events in bits 0 to 7 and flags 0 to 4 in bits 8 to 12. A timeout value of 0 lets the task wait without limit.
- R7: With a nonzero timeout value T, a task that stays paused for T cycles sets its timeout status, goes idle, and raises no done pulse. The next start pulse clears that timeout status.
- R8: Opcode 5 (jump) loads bits [7:0] into the program counter when the condition bit selected by bits [27:24], XORed with bit 23, is 1. Select values 13 to 15 act as an always-true condition.
- R9: Opcode 6 (stop), and any opcode from 7 to 15, makes the task idle and raises its done output for exactly one cycle.
- R10: At most one task owns the ports in a cycle. When both tasks request in the same cycle the winner alternates, and task 0 wins the first such conflict after reset.
- R11: Both tasks can run at the same time. A task paused on a flag resumes once the other task sets that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_start_i | input | 2 | One-cycle start pulse per task |
| t0_start_pc_i | input | 8 | Task 0 start program counter |
| t1_start_pc_i | input | 8 | Task 1 start program counter |
| t0_page_i | input | 2 | Task 0 page (upper memory address bits) |
| t1_page_i | input | 2 | Task 1 page |
| t0_timeout_i | input | 16 | Task 0 pause timeout in cycles, 0 = none |
| t1_timeout_i | input | 16 | Task 1 pause timeout in cycles, 0 = none |
| event_i | input | 8 | Hardware event levels |
| host_sig_set_i | input | 5 | Host flag set mask |
| host_sig_clr_i | input | 5 | Host flag clear mask |
| sig_o | output | 5 | Shared flags |
| task_busy_o | output | 2 | Task running |
| task_done_o | output | 2 | One-cycle completion pulse |
| task_timeout_o | output | 2 | Pause timeout status |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 10 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read strobe |
| reg_idx_o | output | 4 | Register index |
| reg_wdata_o | output | 32 | Register write data |
| reg_rdata_i | input | 32 | Register read data, same cycle |

## Verification
The assertions assume three things about the inputs. Start pulses and host flag masks are driven between clock edges. The memory returns read data in the same cycle as its acknowledge. The register port returns read data combinationally while the read strobe is high. The bench's memory model acknowledges every request in the cycle it is made, and its register-file model answers reads at once, so both handshakes stay within those assumptions. All stimulus is applied on falling edges, and no pause is left waiting on a condition that never comes without a timeout, so no task can hang the run.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int CMD_W   = 32;
  localparam int NTASK   = 2;
  localparam int OP_MSB  = 31;
  localparam int OP_LSB  = 28;
  localparam int SEL_MSB = 27;
  localparam int SEL_LSB = 24;
  localparam int SEL_W   = SEL_MSB - SEL_LSB + 1;
  localparam int INV_BIT = 23;

  typedef enum logic [3:0] {
    OP_LOAD  = 4'd0,
    OP_UPLD  = 4'd1,
    OP_SETS  = 4'd2,
    OP_CLRS  = 4'd3,
    OP_PAUSE = 4'd4,
    OP_JUMP  = 4'd5,
    OP_STOP  = 4'd6
  } opcode_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DEC, S_OPER, S_EXEC, S_PAUSE
  } tstate_t;
endpackage

// File: rtl/dcs_rst_sync.sv
module dcs_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/dcs_arb.sv
module dcs_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_i,
  output logic [1:0] gnt_o
);
  logic conflict;
  logic nxt_q, nxt_n;

  assign conflict = &req_i;

  always_comb begin
    gnt_o = req_i;
    if (conflict) gnt_o = nxt_q ? 2'b10 : 2'b01;
    nxt_n = gnt_o[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        nxt_q <= 1'b0;
    else if (conflict) nxt_q <= nxt_n;
  end

  // R10: a single owner, and only a requester
  p_gnt_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));
  p_gnt_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o & ~req_i) == 2'b00);
  p_alternate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && gnt_o[0]) |=> (conflict ? gnt_o[1] : 1'b1));
endmodule

// File: rtl/dcs_sigflags.sv
module dcs_sigflags #(
  parameter int NSIG = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] set_i,
  input  logic [NSIG-1:0] clr_i,
  output logic [NSIG-1:0] sig_o
);
  logic [NSIG-1:0] sig_q, sig_n;
  logic            upd;

  assign upd = (|set_i) | (|clr_i);

  always_comb sig_n = (sig_q & ~clr_i) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sig_q <= '0;
    else if (upd) sig_q <= sig_n;
  end

  assign sig_o = sig_q;

  // R5: set requests land, and win over clear requests
  p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((sig_o & $past(set_i)) == $past(set_i)));
  p_clr_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((sig_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/dcs_task.sv
module dcs_task
  import dcs_pkg::*;
#(
  parameter int PCW  = 8,
  parameter int PGW  = 2,
  parameter int RIW  = 4,
  parameter int NSIG = 5,
  parameter int CW   = 13,
  parameter int TOW  = 16,
  localparam int AW  = PCW + PGW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PCW-1:0]   start_pc_i,
  input  logic [PGW-1:0]   page_i,
  input  logic [TOW-1:0]   timeout_i,
  input  logic [CW-1:0]    cond_i,
  input  logic             gnt_i,
  input  logic             mem_ack_i,
  input  logic [CMD_W-1:0] mem_rdata_i,
  input  logic [CMD_W-1:0] reg_rdata_i,
  output logic             req_o,
  output logic             use_mem_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [CMD_W-1:0] mem_wdata_o,
  output logic             reg_wr_o,
  output logic             reg_rd_o,
  output logic [RIW-1:0]   reg_idx_o,
  output logic [CMD_W-1:0] reg_wdata_o,
  output logic [NSIG-1:0]  sig_set_o,
  output logic [NSIG-1:0]  sig_clr_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o
);
  localparam int SELN = 1 << SEL_W;

  tstate_t          st, st_n;
  logic [PCW-1:0]   pc, pc_n;
  logic [CMD_W-1:0] ir, opr;
  logic [TOW-1:0]   cnt, cnt_n;
  logic             done_q, done_n, tmo_q, tmo_n;
  logic             ir_ld, opr_ld, take;
  logic [SELN-1:0]  cond_ext;
  opcode_t          op;
  logic             unused_bits;

  assign op          = opcode_t'(ir[OP_MSB:OP_LSB]);
  assign cond_ext    = {{(SELN-CW){1'b1}}, cond_i};
  assign take        = cond_ext[ir[SEL_MSB:SEL_LSB]] ^ ir[INV_BIT];
  assign unused_bits = ^ir[INV_BIT-1:CW];

  always_comb begin
    st_n = st; pc_n = pc; cnt_n = cnt; tmo_n = tmo_q; done_n = 1'b0;
    ir_ld = 1'b0; opr_ld = 1'b0;
    req_o = 1'b0; use_mem_o = 1'b0; mem_we_o = 1'b0;
    mem_addr_o = {page_i, pc};
    reg_wr_o = 1'b0; reg_rd_o = 1'b0;
    sig_set_o = '0; sig_clr_o = '0;
    unique case (st)
      S_IDLE: if (start_i) begin
        st_n = S_FETCH; pc_n = start_pc_i; tmo_n = 1'b0;
      end
      S_FETCH: begin
        req_o = 1'b1; use_mem_o = 1'b1;
        if (gnt_i && mem_ack_i) begin
          ir_ld = 1'b1; pc_n = pc + 1'b1; st_n = S_DEC;
        end
      end
      S_DEC: begin
        case (op)
          OP_LOAD, OP_UPLD: st_n = S_OPER;
          OP_SETS: begin sig_set_o = ir[NSIG-1:0]; st_n = S_FETCH; end
          OP_CLRS: begin sig_clr_o = ir[NSIG-1:0]; st_n = S_FETCH; end
          OP_PAUSE: begin cnt_n = '0; st_n = S_PAUSE; end
          OP_JUMP: begin
            if (take) pc_n = ir[PCW-1:0];
            st_n = S_FETCH;
          end
          default: begin st_n = S_IDLE; done_n = 1'b1; end
        endcase
      end
      S_OPER: begin
        req_o = 1'b1; use_mem_o = 1'b1;
        if (gnt_i && mem_ack_i) begin
          opr_ld = 1'b1; pc_n = pc + 1'b1; st_n = S_EXEC;
        end
      end
      S_EXEC: begin
        req_o = 1'b1;
        if (op == OP_LOAD) begin
          reg_wr_o = 1'b1;
          if (gnt_i) st_n = S_FETCH;
        end else begin
          reg_rd_o = 1'b1; use_mem_o = 1'b1; mem_we_o = 1'b1;
          mem_addr_o = opr[AW-1:0];
          if (gnt_i && mem_ack_i) st_n = S_FETCH;
        end
      end
      S_PAUSE: begin
        if (|(cond_i & ir[CW-1:0])) st_n = S_FETCH;
        else if (timeout_i != '0) begin
          if ((cnt + 1'b1) == timeout_i) begin
            st_n = S_IDLE; tmo_n = 1'b1;
          end else cnt_n = cnt + 1'b1;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pc <= '0; cnt <= '0; done_q <= 1'b0; tmo_q <= 1'b0;
      ir <= '0; opr <= '0;
    end else begin
      st <= st_n; pc <= pc_n; cnt <= cnt_n; done_q <= done_n; tmo_q <= tmo_n;
      if (ir_ld)  ir  <= mem_rdata_i;
      if (opr_ld) opr <= mem_rdata_i;
    end
  end

  assign reg_idx_o   = ir[RIW-1:0];
  assign reg_wdata_o = opr;
  assign mem_wdata_o = reg_rdata_i;
  assign busy_o      = (st != S_IDLE);
  assign done_o      = done_q;
  assign timeout_o   = tmo_q;

  p_start_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && req_o && !timeout_o));
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_tmo_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !busy_o);
endmodule

// File: rtl/dual_cmd_seq.sv
module dual_cmd_seq
  import dcs_pkg::*;
#(
  parameter int PCW  = 8,
  parameter int PGW  = 2,
  parameter int RIW  = 4,
  parameter int EVW  = 8,
  parameter int NSIG = 5,
  parameter int TOW  = 16,
  localparam int AW  = PCW + PGW,
  localparam int CW  = EVW + NSIG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       task_start_i,
  input  logic [PCW-1:0]   t0_start_pc_i,
  input  logic [PCW-1:0]   t1_start_pc_i,
  input  logic [PGW-1:0]   t0_page_i,
  input  logic [PGW-1:0]   t1_page_i,
  input  logic [TOW-1:0]   t0_timeout_i,
  input  logic [TOW-1:0]   t1_timeout_i,
  input  logic [EVW-1:0]   event_i,
  input  logic [NSIG-1:0]  host_sig_set_i,
  input  logic [NSIG-1:0]  host_sig_clr_i,
  output logic [NSIG-1:0]  sig_o,
  output logic [1:0]       task_busy_o,
  output logic [1:0]       task_done_o,
  output logic [1:0]       task_timeout_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [CMD_W-1:0] mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [CMD_W-1:0] mem_rdata_i,
  output logic             reg_wr_o,
  output logic             reg_rd_o,
  output logic [RIW-1:0]   reg_idx_o,
  output logic [CMD_W-1:0] reg_wdata_o,
  input  logic [CMD_W-1:0] reg_rdata_i
);
  logic                 srst_n;
  logic [NTASK-1:0]     t_req, t_mem, t_we, t_wr, t_rd, gnt;
  logic [PCW-1:0]       t_pc   [NTASK];
  logic [PGW-1:0]       t_page [NTASK];
  logic [TOW-1:0]       t_tmo  [NTASK];
  logic [AW-1:0]        t_addr [NTASK];
  logic [CMD_W-1:0]     t_mwd  [NTASK];
  logic [CMD_W-1:0]     t_rwd  [NTASK];
  logic [RIW-1:0]       t_idx  [NTASK];
  logic [NSIG-1:0]      t_set  [NTASK];
  logic [NSIG-1:0]      t_clr  [NTASK];
  logic [NSIG-1:0]      set_all, clr_all;
  logic [CW-1:0]        cond;

  assign t_pc[0] = t0_start_pc_i;  assign t_pc[1] = t1_start_pc_i;
  assign t_page[0] = t0_page_i;    assign t_page[1] = t1_page_i;
  assign t_tmo[0] = t0_timeout_i;  assign t_tmo[1] = t1_timeout_i;
  assign cond = {sig_o, event_i};

  dcs_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(srst_n));

  dcs_arb u_arb (.clk(clk), .rst_n(srst_n), .req_i(t_req), .gnt_o(gnt));

  for (genvar g = 0; g < NTASK; g++) begin : g_task
    dcs_task #(
      .PCW(PCW), .PGW(PGW), .RIW(RIW), .NSIG(NSIG), .CW(CW), .TOW(TOW)
    ) u_task (
      .clk(clk), .rst_n(srst_n),
      .start_i(task_start_i[g]), .start_pc_i(t_pc[g]), .page_i(t_page[g]),
      .timeout_i(t_tmo[g]), .cond_i(cond),
      .gnt_i(gnt[g]), .mem_ack_i(mem_ack_i),
      .mem_rdata_i(mem_rdata_i), .reg_rdata_i(reg_rdata_i),
      .req_o(t_req[g]), .use_mem_o(t_mem[g]), .mem_we_o(t_we[g]),
      .mem_addr_o(t_addr[g]), .mem_wdata_o(t_mwd[g]),
      .reg_wr_o(t_wr[g]), .reg_rd_o(t_rd[g]), .reg_idx_o(t_idx[g]),
      .reg_wdata_o(t_rwd[g]),
      .sig_set_o(t_set[g]), .sig_clr_o(t_clr[g]),
      .busy_o(task_busy_o[g]), .done_o(task_done_o[g]),
      .timeout_o(task_timeout_o[g])
    );
  end

  always_comb begin
    mem_req_o = 1'b0; mem_we_o = 1'b0; mem_addr_o = '0; mem_wdata_o = '0;
    reg_wr_o = 1'b0; reg_rd_o = 1'b0; reg_idx_o = '0; reg_wdata_o = '0;
    set_all = host_sig_set_i; clr_all = host_sig_clr_i;
    for (int i = 0; i < NTASK; i++) begin
      set_all = set_all | t_set[i];
      clr_all = clr_all | t_clr[i];
      if (gnt[i]) begin
        mem_req_o = t_mem[i]; mem_we_o = t_we[i];
        mem_addr_o = t_addr[i]; mem_wdata_o = t_mwd[i];
        reg_wr_o = t_wr[i]; reg_rd_o = t_rd[i];
        reg_idx_o = t_idx[i]; reg_wdata_o = t_rwd[i];
      end
    end
  end

  dcs_sigflags #(.NSIG(NSIG)) u_sig (
    .clk(clk), .rst_n(srst_n), .set_i(set_all), .clr_i(clr_all), .sig_o(sig_o)
  );

  p_we_needs_req_r4: assert property (@(posedge clk) disable iff (!srst_n)
    mem_we_o |-> (mem_req_o && reg_rd_o));
  p_reg_one_strobe_r3: assert property (@(posedge clk) disable iff (!srst_n)
    !(reg_wr_o && reg_rd_o));
endmodule

// File: tb/dual_cmd_seq_tb_top.sv
module dual_cmd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  start;
  logic [7:0]  pc0, pc1;
  logic [1:0]  pg0, pg1;
  logic [15:0] to0, to1;
  logic [7:0]  ev;
  logic [4:0]  hset, hclr, sig;
  logic [1:0]  busy, done, tmo;
  logic        mem_req, mem_we, mem_ack, reg_wr, reg_rd;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata, reg_wdata, reg_rdata;
  logic [3:0]  reg_idx;

  logic [31:0] mem [1024];
  logic [31:0] rf  [16];
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  dual_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .task_start_i(start),
    .t0_start_pc_i(pc0), .t1_start_pc_i(pc1), .t0_page_i(pg0), .t1_page_i(pg1),
    .t0_timeout_i(to0), .t1_timeout_i(to1), .event_i(ev),
    .host_sig_set_i(hset), .host_sig_clr_i(hclr), .sig_o(sig),
    .task_busy_o(busy), .task_done_o(done), .task_timeout_o(tmo),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .reg_idx_o(reg_idx),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr];
  assign reg_rdata = rf[reg_idx];

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    if (reg_wr) rf[reg_idx] <= reg_wdata;
  end

  // host flag vectors: {set, clear, expected flags afterwards}
  localparam logic [14:0] HVEC [5] = '{
    {5'b00000, 5'b11111, 5'b00000},
    {5'b00011, 5'b00000, 5'b00011},
    {5'b10000, 5'b00001, 5'b10010},
    {5'b00100, 5'b00100, 5'b10110},
    {5'b00000, 5'b11111, 5'b00000}
  };

  function automatic logic [31:0] cmd(input logic [3:0] op, input logic [27:0] arg);
    return {op, arg};
  endfunction
  function automatic logic [31:0] jmp(input logic [3:0] sel, input logic inv, input logic [7:0] tgt);
    return {4'd5, sel, inv, 15'd0, tgt};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic go(input logic [1:0] m);
    @(negedge clk); start = m;
    @(negedge clk); start = 2'b00;
  endtask

  task automatic host(input logic [4:0] s, input logic [4:0] c);
    @(negedge clk); hset = s; hclr = c;
    @(negedge clk); hset = '0; hclr = '0;
  endtask

  task automatic wait_done(input logic [1:0] which, output logic ok);
    logic [1:0] seen = 2'b00;
    for (int i = 0; i < 500; i++) begin
      seen = seen | done;
      if ((seen & which) == which) break;
      @(negedge clk);
    end
    ok = ((seen & which) == which);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic ok;
    logic [1:0] dseen;
    rst_n = 1'b0; start = '0; pc0 = '0; pc1 = '0; pg0 = 2'd0; pg1 = 2'd1;
    to0 = '0; to1 = '0; ev = '0; hset = '0; hclr = '0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    for (int i = 0; i < 16; i++) rf[i] = 32'h0;
    rf[5] = 32'h1234_5678;
    mem[10'h000] = cmd(4'd6, 0);
    mem[10'h100] = cmd(4'd6, 0);
    mem[10'h010] = cmd(4'd0, 28'd3);  mem[10'h011] = 32'hCAFE_0001;
    mem[10'h012] = cmd(4'd1, 28'd3);  mem[10'h013] = 32'h0000_0300;
    mem[10'h014] = cmd(4'd1, 28'd5);  mem[10'h015] = 32'h0000_0301;
    mem[10'h016] = cmd(4'd6, 0);
    mem[10'h120] = cmd(4'd2, 28'h15); mem[10'h121] = cmd(4'd3, 28'h01);
    mem[10'h122] = cmd(4'd6, 0);
    mem[10'h030] = cmd(4'd4, 28'h004); mem[10'h031] = cmd(4'd2, 28'h08);
    mem[10'h032] = cmd(4'd6, 0);
    mem[10'h050] = cmd(4'd0, 28'd7);  mem[10'h051] = 32'hA5A5_0007;
    mem[10'h052] = cmd(4'd2, 28'h02); mem[10'h053] = cmd(4'd6, 0);
    mem[10'h150] = cmd(4'd4, 28'h200);
    mem[10'h151] = cmd(4'd1, 28'd7);  mem[10'h152] = 32'h0000_0310;
    mem[10'h153] = cmd(4'd6, 0);
    mem[10'h160] = cmd(4'd4, 28'h001); mem[10'h161] = cmd(4'd6, 0);
    mem[10'h070] = jmp(4'd15, 1'b0, 8'h74); mem[10'h071] = cmd(4'd2, 28'h01);
    mem[10'h072] = cmd(4'd6, 0);
    mem[10'h074] = jmp(4'd10, 1'b0, 8'h78); mem[10'h075] = cmd(4'd2, 28'h02);
    mem[10'h076] = cmd(4'd6, 0);
    mem[10'h078] = cmd(4'd2, 28'h04); mem[10'h079] = cmd(4'd6, 0);
    mem[10'h080] = jmp(4'd10, 1'b1, 8'h84); mem[10'h081] = cmd(4'd2, 28'h08);
    mem[10'h082] = cmd(4'd6, 0);
    mem[10'h084] = cmd(4'd2, 28'h10); mem[10'h085] = cmd(4'd6, 0);
    mem[10'h090] = 32'hF000_0000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 busy", {30'd0, busy}, 0);
    chk("R1 flags", {27'd0, sig}, 0);
    chk("R1 mem_req", {31'd0, mem_req}, 0);
    chk("R1 done/timeout", {28'd0, done, tmo}, 0);

    // R10 first conflict goes to task 0, next one to task 1
    go(2'b11);
    chk("R10 first conflict owner", {21'd0, mem_req, mem_addr}, {21'd0, 1'b1, 10'h000});
    wait_done(2'b11, ok);
    chk("R9 both stop", {31'd0, ok}, 1);
    chk("R9 idle after stop", {30'd0, busy}, 0);
    repeat (3) @(negedge clk);
    go(2'b11);
    chk("R10 second conflict owner", {21'd0, mem_req, mem_addr}, {21'd0, 1'b1, 10'h100});
    wait_done(2'b11, ok);

    // R3 / R4 load and upload
    pc0 = 8'h10; go(2'b01); wait_done(2'b01, ok);
    chk("R3 load register", rf[3], 32'hCAFE_0001);
    chk("R4 upload loaded reg", mem[10'h300], 32'hCAFE_0001);
    chk("R4 upload preset reg", mem[10'h301], 32'h1234_5678);

    // R5 task flag set/clear
    pc1 = 8'h20; go(2'b10); wait_done(2'b10, ok);
    chk("R5 task set/clear", {27'd0, sig}, 32'h14);
    host(5'b00000, 5'b11111);

    // R6 pause on event, R2 restart while busy ignored
    pc0 = 8'h30; go(2'b01);
    repeat (20) @(negedge clk);
    chk("R6 still paused, no timeout", {30'd0, busy[0], tmo[0]}, 32'h2);
    chk("R6 no advance while paused", {31'd0, sig[3]}, 0);
    pc0 = 8'h00; go(2'b01);
    repeat (3) @(negedge clk);
    ev[2] = 1'b1;
    wait_done(2'b01, ok);
    chk("R6 resume on event", {31'd0, ok}, 1);
    chk("R2 busy start ignored", {31'd0, sig[3]}, 1);
    ev = '0;
    host(5'b00000, 5'b11111);

    // R11 concurrent tasks through a flag
    pc0 = 8'h50; pc1 = 8'h50; go(2'b11);
    wait_done(2'b11, ok);
    chk("R11 both complete", {31'd0, ok}, 1);
    chk("R11 uploaded after flag", mem[10'h310], 32'hA5A5_0007);
    host(5'b00000, 5'b11111);

    // R7 timeout
    to1 = 16'd10; pc1 = 8'h60; go(2'b10);
    repeat (4) @(negedge clk);
    chk("R7 paused before timeout", {30'd0, busy[1], tmo[1]}, 32'h2);
    dseen = 2'b00;
    for (int i = 0; i < 20; i++) begin @(negedge clk); dseen = dseen | done; end
    chk("R7 timeout set, idle", {30'd0, busy[1], tmo[1]}, 32'h1);
    chk("R7 no done on timeout", {31'd0, dseen[1]}, 0);
    pc1 = 8'h00; go(2'b10);
    chk("R7 restart clears timeout", {31'd0, tmo[1]}, 0);
    wait_done(2'b10, ok);
    to1 = '0;

    // R8 jumps
    pc0 = 8'h70; go(2'b01); wait_done(2'b01, ok);
    chk("R8 always and not-taken", {27'd0, sig}, 32'h02);
    host(5'b00000, 5'b11111);
    pc0 = 8'h80; go(2'b01); wait_done(2'b01, ok);
    chk("R8 inverted taken", {27'd0, sig}, 32'h10);
    host(5'b00000, 5'b11111);

    // R9 unused opcode stops
    pc0 = 8'h90; go(2'b01); wait_done(2'b01, ok);
    chk("R9 unused opcode stops", {30'd0, ok, busy[0]}, 32'h2);

    // R5 host flag vectors, set wins over clear
    foreach (HVEC[i]) begin
      @(negedge clk); hset = HVEC[i][14:10]; hclr = HVEC[i][9:5];
      @(negedge clk); hset = '0; hclr = '0;
      chk("R5 host flags", {27'd0, sig}, {27'd0, HVEC[i][4:0]});
    end

    summary();
    $finish;
  end
endmodule